// File: doc/BRIEF.md
# Modem Status Derivation and Change Tracking

This block holds the modem control register of a 16550-style serial port and produces the matching modem status register from it. The port has no real modem input pins. Instead, the four status lines are produced inside the block.

When the loopback control bit is set, each status line takes its value from one of the control outputs. When loopback is clear, the carrier-detect and data-set-ready lines report fixed asserted levels, and clear-to-send and ring report deasserted.

Each write to the control register compares the old status lines with the new ones. Any change sets a sticky change flag. A read strobe on the status register returns the current value and then clears those flags. The block drives a single pending output to the interrupt logic whenever any change flag is set.

Top module: `mdm_status_top`

## Requirements
- R1: After reset, the control readback is 0x00, the status readback is 0xA0 and `deltaPending` is 0.
- R2: A control write keeps only data bits 4:0. Control readback bits 7:5 always read 0.
- R3: With control bit 4 (loopback) set, status bits map from control bits as follows: bit 4 (clear-to-send) comes from control bit 1, bit 5 (set-ready) from control bit 0, bit 6 (ring) from control bit 2, and bit 7 (carrier) from control bit 3.
- R4: With control bit 4 clear, status bits 7:4 read 4'b1010: carrier and set-ready are high, ring and clear-to-send are low.
- R5: A control write sets change flags where the line level differs between the old and new control values. Bit 0 flags a clear-to-send change, bit 1 a set-ready change and bit 3 a carrier change.
- R6: Status bit 2 (ring trailing edge) is set only when the ring line goes from 1 to 0. A 0-to-1 ring change sets no flag.
- R7: Change flags in bits 3:0 are sticky. A later control write never clears them, while the line bits 7:4 follow the new control value.
- R8: A `rdStatus` strobe leaves the status value visible in that cycle and clears bits 3:0 on the next edge. Flags raised by a control write in the same cycle are still set afterwards.
- R9: A write with `wrSel`=1 (status register) changes neither the control nor the status readback.
- R10: `deltaPending` is 1 exactly when any of status bits 3:0 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | Write target: 0 = control register, 1 = status register (ignored) |
| wrData | input | 8 | Write data |
| rdStatus | input | 1 | Status read strobe; clears the change flags after this cycle |
| ctrlQ | output | 8 | Control register readback |
| statusQ | output | 8 | Status register readback |
| deltaPending | output | 1 | Any change flag set |

## Verification
The bench goes after several corner cases.

- **Ring edge direction.** A ring transition from 0 to 1 must not raise the trailing-edge flag. A design that treated ring like the other lines would set bit 2 on every toggle.
- **Entering and leaving loopback.** Writes that enter or leave loopback flip several lines at once. A swapped line mapping would show up in bits 7:4, or as the wrong flag in bits 3:0.
- **Sticky flags.** Repeated control writes must keep earlier flags. A design that rebuilt the low nibble on each write would lose them.
- **Read and write in the same cycle.** A read strobe that arrives together with a flag-raising write must keep the new flags. A design that let the clear win would drop a change.
- **Ignored status writes.** Writes aimed at the status register must leave both readbacks unchanged.

After these directed cases, a pseudo-random stream is compared every cycle against a behavioural model.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  localparam int LINE_N = 4;
  localparam int IDX_CTS = 0;
  localparam int IDX_DSR = 1;
  localparam int IDX_RI  = 2;
  localparam int IDX_DCD = 3;

  typedef struct packed {
    logic loadCtrl;
    logic clearDelta;
  } mdmStrobe_t;
endpackage

// File: rtl/mdm_ctrl.sv
module mdm_ctrl
  import mdm_pkg::*;
(
  input  logic       wrEn,
  input  logic       wrSel,
  input  logic       rdStatus,
  output mdmStrobe_t strobe
);
  // A write aimed at the status register produces no strobe at all.
  always_comb begin
    strobe.loadCtrl   = wrEn & ~wrSel;
    strobe.clearDelta = rdStatus;
  end
endmodule

// File: rtl/mdm_datapath.sv
module mdm_datapath
  import mdm_pkg::*;
#(
  parameter int CTRL_W = 5,
  parameter int LOOP_BIT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  mdmStrobe_t        strobe,
  input  logic [CTRL_W-1:0] ctrlIn,
  output logic [CTRL_W-1:0] ctrlReg,
  output logic [LINE_N-1:0] lineLvl,
  output logic [LINE_N-1:0] deltaReg
);
  logic [LINE_N-1:0] newLvl;
  logic [LINE_N-1:0] setDelta;

  // Line order: [0]=clear-to-send [1]=set-ready [2]=ring [3]=carrier
  function automatic logic [LINE_N-1:0] deriveLines(input logic [CTRL_W-1:0] c);
    logic [LINE_N-1:0] l;
    if (c[LOOP_BIT]) begin
      l[IDX_CTS] = c[1];
      l[IDX_DSR] = c[0];
      l[IDX_RI]  = c[2];
      l[IDX_DCD] = c[3];
    end else begin
      l = '0;
      l[IDX_DSR] = 1'b1;
      l[IDX_DCD] = 1'b1;
    end
    return l;
  endfunction

  assign lineLvl = deriveLines(ctrlReg);
  assign newLvl  = deriveLines(ctrlIn);

  for (genvar i = 0; i < LINE_N; i++) begin : g_delta
    if (i == IDX_RI) begin : g_fall
      assign setDelta[i] = strobe.loadCtrl & lineLvl[i] & ~newLvl[i];
    end else begin : g_any
      assign setDelta[i] = strobe.loadCtrl & (lineLvl[i] ^ newLvl[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg  <= '0;
      deltaReg <= '0;
    end else begin
      if (strobe.loadCtrl) ctrlReg <= ctrlIn;
      deltaReg <= (strobe.clearDelta ? '0 : deltaReg) | setDelta;
    end
  end
endmodule

// File: rtl/mdm_status_top.sv
module mdm_status_top
  import mdm_pkg::*;
#(
  parameter int REG_W = 8,
  parameter int CTRL_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [REG_W-1:0] wrData,
  input  logic             rdStatus,
  output logic [REG_W-1:0] ctrlQ,
  output logic [REG_W-1:0] statusQ,
  output logic             deltaPending
);
  localparam int LOOP_BIT = CTRL_W - 1;

  mdmStrobe_t        strobe;
  logic [CTRL_W-1:0] ctrlReg;
  logic [LINE_N-1:0] lineLvl;
  logic [LINE_N-1:0] deltaReg;
  logic              unusedWrHi;

  assign unusedWrHi = ^wrData[REG_W-1:CTRL_W];

  mdm_ctrl u_ctrl (
    .wrEn(wrEn), .wrSel(wrSel), .rdStatus(rdStatus), .strobe(strobe)
  );

  mdm_datapath #(.CTRL_W(CTRL_W), .LOOP_BIT(LOOP_BIT)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .ctrlIn(wrData[CTRL_W-1:0]), .ctrlReg(ctrlReg),
    .lineLvl(lineLvl), .deltaReg(deltaReg)
  );

  assign ctrlQ        = {{(REG_W-CTRL_W){1'b0}}, ctrlReg};
  assign statusQ      = {lineLvl, deltaReg};
  assign deltaPending = |deltaReg;
endmodule

// File: rtl/mdm_status_chk.sv
module mdm_status_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic       wrSel,
  input logic       rdStatus,
  input logic [7:0] ctrlQ,
  input logic [7:0] statusQ,
  input logic       deltaPending
);
  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    ctrlQ[7:5] == 3'b000);

  a_r4_fixed_levels: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlQ[4] |-> statusQ[7:4] == 4'b1010);

  a_r6_ring_falling: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusQ[2]) |-> ($past(statusQ[6]) && !statusQ[6]));

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrSel && !rdStatus) |=>
      ((statusQ[3:0] & $past(statusQ[3:0])) == $past(statusQ[3:0])));

  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (rdStatus && !(wrEn && !wrSel)) |=> statusQ[3:0] == 4'b0000);

  a_r9_status_write: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel && !rdStatus) |=> ($stable(statusQ) && $stable(ctrlQ)));

  a_r10_pending: assert property (@(posedge clk) disable iff (!rstN)
    deltaPending == (statusQ[3:0] != 4'b0000));
endmodule

bind mdm_status_top mdm_status_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .rdStatus(rdStatus),
  .ctrlQ(ctrlQ), .statusQ(statusQ), .deltaPending(deltaPending)
);

// File: tb/mdm_status_top_tb.sv
module mdm_status_top_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic       wrSel = 1'b0;
  logic [7:0] wrData = '0;
  logic       rdStatus = 1'b0;
  logic [7:0] ctrlQ;
  logic [7:0] statusQ;
  logic       deltaPending;

  int total = 0;
  int bad = 0;
  int mdlCtrl = 0;
  int mdlDelta = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  mdm_status_top u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .rdStatus(rdStatus), .ctrlQ(ctrlQ), .statusQ(statusQ),
    .deltaPending(deltaPending)
  );

  // Model line nibble: bit0 cts, bit1 dsr, bit2 ri, bit3 dcd
  function automatic int mdlLines(int c);
    int r;
    if ((c & 16) != 0) begin
      r = 0;
      if ((c & 2) != 0) r += 1;
      if ((c & 1) != 0) r += 2;
      if ((c & 4) != 0) r += 4;
      if ((c & 8) != 0) r += 8;
    end else begin
      r = 10;
    end
    return r;
  endfunction

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic compareAll(string tag);
    check({tag, " ctrl"}, int'(ctrlQ), mdlCtrl);
    check({tag, " status"}, int'(statusQ), mdlLines(mdlCtrl) * 16 + mdlDelta);
    check({tag, " R10 pending"}, int'(deltaPending), (mdlDelta != 0) ? 1 : 0);
  endtask

  task automatic step(bit we, bit sel, int data, bit rd, string tag);
    int oldL;
    int newL;
    int setD;
    int newC;
    @(negedge clk);
    wrEn = we; wrSel = sel; wrData = data[7:0]; rdStatus = rd;
    setD = 0;
    newC = mdlCtrl;
    if (we && !sel) begin
      newC = data & 31;
      oldL = mdlLines(mdlCtrl);
      newL = mdlLines(newC);
      setD = (oldL ^ newL) & 11;
      if ((oldL & 4) != 0 && (newL & 4) == 0) setD |= 4;
    end
    mdlDelta = (rd ? 0 : mdlDelta) | setD;
    mdlCtrl = newC;
    @(posedge clk);
    #1;
    compareAll(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #1;
    check("R1 reset ctrl", int'(ctrlQ), 8'h00);
    check("R1 reset status", int'(statusQ), 8'hA0);
    check("R1 reset pending", int'(deltaPending), 0);

    step(1, 0, 8'hFF, 0, "R2 mask");
    check("R2 ctrl upper", int'(ctrlQ), 8'h1F);
    check("R3 all high", int'(statusQ), 8'hF1);
    step(1, 0, 8'h10, 0, "R6 ring fall");
    check("R6 all flags", int'(statusQ), 8'h0F);
    step(0, 0, 0, 1, "R8 read");
    check("R8 cleared", int'(statusQ), 8'h00);
    step(1, 1, 8'hFF, 0, "R9 ignored");
    check("R9 status kept", int'(statusQ), 8'h00);
    check("R9 ctrl kept", int'(ctrlQ), 8'h10);
    step(1, 0, 8'h14, 0, "R6 ring rise");
    check("R6 no flag on rise", int'(statusQ), 8'h40);
    step(1, 0, 8'h12, 0, "R3 cts");
    check("R3 cts and teri", int'(statusQ), 8'h15);
    step(1, 0, 8'h13, 0, "R7 sticky");
    check("R7 flags kept", int'(statusQ), 8'h37);
    step(1, 0, 8'h19, 1, "R8 read with write");
    check("R8 new flags kept", int'(statusQ), 8'hA9);
    step(1, 0, 8'h00, 0, "R4 leave loop");
    check("R4 fixed levels", int'(statusQ[7:4]), 4'hA);
    step(0, 0, 0, 1, "R8 read2");

    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0], lfsr[1] & lfsr[2], int'(lfsr[15:8]), lfsr[3] & lfsr[4],
           "R5 random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule